// File: doc/BRIEF.md
# Cartridge ROM Bank-Switch Mapper

This block lets a 64K cartridge ROM sit behind the 32K cartridge window of an 8-bit CPU system. The window has two 16K halves. The lower half always shows the first 16K of the ROM. The upper half shows one of four 16K banks. The host decodes four active-low slot selects, each covering 8K of the window. The mapper reads them together with the CPU address bus and produces the ROM address and a ROM enable.

A bank change is requested by an access pattern, not by a data write. The pattern sits in the system RAM-mirror area, so none of the cartridge selects are active. The mapper never drives the data bus there; it only watches the address. The request must be present on two consecutive clock samples with the same bank number before the bank register loads. This filters out addresses that are only passing through during a transition.

In the default mode the mapper does not look at the bus strobes. An I/O cycle whose upper address byte lands in the trigger range therefore switches banks. A mode input adds a stricter qualification: the trigger then needs a memory request and no I/O request.

Top module: `cart_bank_mapper`

## Requirements
- R1: While reset is asserted and after it is released, the bank register holds 0, so the upper half of the window shows the first bank (rom_addr[15:14] = 0).
- R2: When cs_n[0] or cs_n[1] is low (fixed half, 0x8000–0xBFFF) and cs_n[3:2] are both high, rom_addr = {2'b00, addr[13:0]}.
- R3: When cs_n[2] or cs_n[3] is low (switchable half, 0xC000–0xFFFF), rom_addr = {bank, addr[13:0]}.
- R4: rom_en is 1 exactly when at least one bit of cs_n is 0.
- R5: A trigger sample requires all four cs_n bits high, addr[14:12] = 3'b111 and addr[11] = 0. The requested bank is addr[10:9]. addr[15] and addr[8:0] are not examined. A refresh-style address whose upper byte is 0x00 never triggers.
- R6: The bank register loads only on a clock edge where a trigger sample is present and a trigger sample with the same bank number was present on the previous edge. The new bank is visible right after that second edge. A trigger seen on only one edge, or two consecutive triggers with different bank numbers, leaves the bank unchanged.
- R7: With safe_en = 0, mreq_n and iorq_n are ignored, so an I/O cycle (iorq_n = 0) whose upper address byte is in the trigger range switches banks.
- R8: With safe_en = 1, a trigger sample also requires mreq_n = 0 and iorq_n = 1. An I/O cycle in the trigger range leaves the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address bus |
| cs_n | input | 4 | Active-low slot selects, one per 8K of the cartridge window, lowest address first |
| mreq_n | input | 1 | Active-low memory request, used only in safe mode |
| iorq_n | input | 1 | Active-low I/O request, used only in safe mode |
| safe_en | input | 1 | 1 selects the strobe-qualified trigger |
| rom_addr | output | 16 | ROM address: bank field plus window offset |
| rom_en | output | 1 | Active-high ROM enable |

## Verification
The bank register is internal, so a wrong value shows up only in rom_addr[15:14] on the next access to the switchable half. The fixed half must never show it. The bench therefore reads the upper half right after each trigger attempt, so a missing, extra or early load appears within one cycle of the edge where the design should or should not have loaded. A wrong trigger qualification appears the same way. The cases covered are a select held low, addr[11] set, a single-sample pulse, a bank number that changes between samples, and the strobe rules in each mode. The cycle-level model flags a load that is one edge late or early, because the upper-half read follows immediately.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int AW     = 16,
  parameter int WIN_AW = 14,
  parameter int BANK_W = 2,
  parameter int SEL_LSB = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [3:0]               cs_n,
  input  logic                     mreq_n,
  input  logic                     iorq_n,
  input  logic                     safe_en,
  output logic [WIN_AW+BANK_W-1:0] rom_addr,
  output logic                     rom_en
);
  localparam int ROM_AW = WIN_AW + BANK_W;

  logic [BANK_W-1:0] bank, sel_q, sel_now;
  logic trig_q, trig_now, pattern, strobe_ok, upper_sel;

  assign pattern   = (&cs_n) && (&addr[14:12]) && !addr[11];
  assign strobe_ok = !safe_en || (!mreq_n && iorq_n);
  assign trig_now  = pattern && strobe_ok;
  assign sel_now   = addr[SEL_LSB +: BANK_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      sel_q  <= '0;
      bank   <= '0;
    end else begin
      trig_q <= trig_now;
      sel_q  <= sel_now;
      if (trig_now && trig_q && sel_now == sel_q)
        bank <= sel_now;
    end
  end

  assign upper_sel = !(cs_n[3] && cs_n[2]);
  assign rom_addr  = {upper_sel ? bank : {BANK_W{1'b0}}, addr[WIN_AW-1:0]};
  assign rom_en    = !(&cs_n);

  AST_RESET_BANK: assert property (@(posedge clk) !rst_n |=> bank == '0); // R1
  AST_FIXED_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n[3:2] == 2'b11 && !(&cs_n)) |-> rom_addr[ROM_AW-1:WIN_AW] == '0); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> rom_addr[WIN_AW-1:0] == addr[WIN_AW-1:0]); // R3
  AST_NO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_q |=> $stable(bank)); // R6
  AST_LOAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && trig_now && sel_q == sel_now) |=> bank == $past(addr[SEL_LSB +: BANK_W])); // R5
  AST_SAFE_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_en && !iorq_n) |=> $stable(bank)); // R8
  AST_CS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |=> $stable(bank)); // R5
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [3:0] cs_n = 4'hF;
  logic mreq_n = 1'b1, iorq_n = 1'b1, safe_en = 1'b0;
  logic [15:0] rom_addr;
  logic rom_en;

  int checks = 0, errors = 0;
  int m_bank = 0, m_prev_trig = 0, m_prev_sel = 0;
  bit done = 0;

  cart_bank_mapper dut (.clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .safe_en(safe_en),
    .rom_addr(rom_addr), .rom_en(rom_en));

  always #10 clk = ~clk;

  function automatic int exp_addr();
    int hi = (cs_n[2] == 1'b0 || cs_n[3] == 1'b0) ? m_bank : 0;
    return hi * 16384 + int'(addr[13:0]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int trig, sel;
    trig = (cs_n == 4'hF) && (addr[14:12] == 3'b111) && !addr[11] &&
           (!safe_en || (!mreq_n && iorq_n));
    sel = int'(addr[10:9]);
    if (trig && m_prev_trig && sel == m_prev_sel) m_bank = sel;
    m_prev_trig = trig;
    m_prev_sel = sel;
  endtask

  task automatic cyc(input logic [15:0] a, input logic [3:0] c, input logic mr,
                     input logic io, input logic se, input int n);
    for (int i = 0; i < n; i++) begin
      addr = a; cs_n = c; mreq_n = mr; iorq_n = io; safe_en = se;
      #2;
      check(rom_en == !(&cs_n), "R4", rom_en, !(&cs_n));
      if (!(&cs_n))
        check(int'(rom_addr) == exp_addr(), (cs_n[3:2] != 2'b11) ? "R3" : "R2",
              rom_addr, exp_addr());
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic bank_is(int exp, string req);
    cyc(16'hC000, 4'b1011, 1'b0, 1'b1, safe_en, 1);
    addr = 16'hE000; cs_n = 4'b0111;
    #2;
    check(int'(rom_addr[15:14]) == exp, req, rom_addr[15:14], exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cs_n = 4'b1011; addr = 16'hC123;
    #1;
    check(rom_addr == 16'h0123, "R1 during reset", rom_addr, 16'h0123);
    @(negedge clk);
    rst_n = 1'b1;
    bank_is(0, "R1");
    cyc(16'h8456, 4'b1110, 1'b0, 1'b1, 1'b0, 1);
    cyc(16'hA456, 4'b1101, 1'b0, 1'b1, 1'b0, 1);
    addr = 16'hA456; cs_n = 4'b1101; #2;
    check(rom_addr == 16'h2456, "R2", rom_addr, 16'h2456);
    check(rom_en == 1'b1, "R4", rom_en, 1);
    cs_n = 4'hF; #1;
    check(rom_en == 1'b0, "R4 idle", rom_en, 0);
    @(negedge clk);
    cyc(16'h7400, 4'hF, 1'b0, 1'b1, 1'b0, 2);
    bank_is(2, "R5 load bank 2");
    addr = 16'hE010; cs_n = 4'b0111; #2;
    check(rom_addr == 16'hA010, "R3", rom_addr, 16'hA010);
    @(negedge clk);
    cyc(16'h7600, 4'hF, 1'b0, 1'b1, 1'b0, 1);
    bank_is(2, "R6 single sample");
    cyc(16'h7000, 4'hF, 1'b0, 1'b1, 1'b0, 1);
    cyc(16'h7600, 4'hF, 1'b0, 1'b1, 1'b0, 1);
    bank_is(2, "R6 changing bank");
    cyc(16'h7800, 4'hF, 1'b0, 1'b1, 1'b0, 3);
    bank_is(2, "R5 A11 set");
    cyc(16'h7000, 4'b1110, 1'b0, 1'b1, 1'b0, 3);
    bank_is(2, "R5 select active");
    cyc(16'h007F, 4'hF, 1'b0, 1'b1, 1'b0, 3);
    bank_is(2, "R5 refresh");
    cyc(16'hF200, 4'hF, 1'b0, 1'b1, 1'b0, 2);
    bank_is(1, "R5 A15 ignored");
    cyc(16'h76BE, 4'hF, 1'b1, 1'b0, 1'b0, 2);
    bank_is(3, "R7 io cycle switches");
    cyc(16'h70BE, 4'hF, 1'b1, 1'b0, 1'b1, 3);
    bank_is(3, "R8 io blocked");
    cyc(16'h72BE, 4'hF, 1'b1, 1'b1, 1'b1, 3);
    bank_is(3, "R8 no strobe blocked");
    cyc(16'h70BE, 4'hF, 1'b0, 1'b1, 1'b1, 2);
    bank_is(0, "R8 memory cycle accepted");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule